// File: doc/BRIEF.md
# Memory-Mapped Asynchronous Serial Port

This block is a full-duplex asynchronous serial port that a processor reaches through a small synchronous register bus. Software writes characters into a transmit queue and reads received characters from a receive queue. Each queue holds up to 16 entries, or can be reduced to a single holding slot. One line-configuration register sets the baud divisor and every framing option together: 5 to 8 data bits, an optional even or odd parity bit, one or two stop bits, and a break that forces the line low. Every received character is stored with its own framing-error, parity-error and overrun flags, so software learns the fate of each character when it reads it.

The bus clock is also the bit-timing reference. A divider produces a tick at 16 times the bit rate. Two state machines run on that tick. The transmitter moves through Idle, Start, Data, Parity and Stop. Idle goes to Start on a tick when the queue holds a character. Start goes to Data after 16 ticks. Data goes to Parity, or to Stop when parity is off, after the last data bit. Parity goes to Stop. Stop goes straight to Start when another character is waiting, and otherwise back to Idle. The receiver moves through Idle, Start, Data, Parity, Stop and WaitHigh. Idle goes to Start on a low sample. Start goes to Data when the line is still low at mid start bit, and back to Idle when it is not. Data and Parity step the same way as in the transmitter. Stop stores the character and goes to Idle when the stop bit is high, or to WaitHigh when it is low. WaitHigh returns to Idle once the line is high again. Separate interrupt outputs request transmit refill and receive service.

Top module: `serial_port_ctrl`

## Requirements
- R1: After reset, `tx_line` is 1 and both interrupts are 0. The status register (address 3) reads 1, meaning receive queue empty, transmit queue not full and not busy. The control register (address 0) and the line register (address 1) both read 0.
- R2: The divisor is in bits [11:0] of the line register. Each serial bit lasts 16*(divisor+1) clock cycles. Characters already queued go out back to back with no idle time between frames.
- R3: Line-register bits [18:17] select the word length: code 0, 1, 2, 3 gives 5, 6, 7, 8 data bits, sent least significant bit first. Received characters are returned zero-extended.
- R4: Line-register bit 15 set gives two stop bits; clear gives one. Stop bits are high.
- R5: Line-register bit 13 enables a parity bit after the data bits. Bit 14 set makes the parity even (parity bit = XOR of the data bits); clear makes it odd.
- R6: While line-register bit 12 is set, `tx_line` is 0. When the bit is cleared on an idle transmitter, the line returns to 1.
- R7: With line-register bit 16 set, each queue holds 16 characters. With it clear, each queue holds one. A write to a full transmit queue is dropped. Characters leave in the order they were written.
- R8: Reading address 2 removes one received character. Bits [7:0] hold the data, bit 8 flags a framing error (low stop bit) and bit 9 flags a parity error. After a framing error the receiver waits for a high line before it looks for a new start bit. Status bit 0 is receive-queue empty and bit 1 is transmit-queue full.
- R9: A character that arrives while the receive queue is full is discarded, and bit 10 is set on the next character that is stored. That flag is then cleared.
- R10: Status bit 2 (busy) stays 1 while the transmit queue holds data or a frame is in flight, until the end of the last stop bit.
- R11: Control bit 0 (address 0) enables the port. While it is 0, nothing is transmitted and nothing is received, but writes still fill the transmit queue.
- R12: `rx_irq` is 1 while the port is enabled and the receive queue is not empty. `tx_irq` is 1 while the port is enabled and the transmit queue holds at most 8 entries in 16-entry mode, or is empty in single mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and bit-timing reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 control, 1 line, 2 data, 3 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| tx_line | output | 1 | Serial transmit output, idle high |
| rx_line | input | 1 | Serial receive input, asynchronous |
| tx_irq | output | 1 | Transmit refill request |
| rx_irq | output | 1 | Receive data available |

## Verification
The embedded assertions check on every cycle that the tick stops while the port is disabled, and that the transmitter never sends more data bits than the word length. They also check that it holds Stop for a second bit when two stop bits are selected, that the queue count tracks accepted pushes, that a pop never hits an empty queue, and that the receiver stays in WaitHigh while the line is low. Only the bench scenarios can show the serial waveform itself. Those scenarios cover exact bit timing across divisors, the parity values and the stop-bit levels. They also cover the per-character error flags after injected bad frames, overrun marking in both queue modes, break, the busy window, and interrupt levels as the queues fill and drain.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int DIV_W  = 12;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic [1:0]       wl_code;
        logic             fifo_en;
        logic             stop2;
        logic             par_even;
        logic             par_en;
        logic             brk;
        logic [DIV_W-1:0] div;
    } line_cfg_t;

    localparam int CFG_W = $bits(line_cfg_t);

    typedef struct packed {
        logic              ovr;
        logic              perr;
        logic              ferr;
        logic [DATA_W-1:0] data;
    } rx_word_t;

    localparam int RXW_W = $bits(rx_word_t);

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PARITY, TX_STOP
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP, RX_WAIT_HIGH
    } rx_state_t;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_LINE = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    function automatic logic [3:0] wl_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    function automatic logic [DATA_W-1:0] wl_mask(input logic [DATA_W-1:0] d,
                                                   input logic [1:0] code);
        return d & ({DATA_W{1'b1}} >> (2'd3 - code));
    endfunction

    function automatic logic par_bit(input logic [DATA_W-1:0] d, input logic even);
        return even ? (^d) : ~(^d);
    endfunction
endpackage

// File: rtl/sp_baud.sv
module sp_baud #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (!en_i)          cnt <= '0;
        else if (cnt >= div_i)   cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    assign tick_o = en_i && (cnt >= div_i);
endmodule

// File: rtl/sp_fifo.sv
module sp_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          single_i,
    input  logic          push_i,
    input  logic [W-1:0]  wdata_i,
    input  logic          pop_i,
    output logic [W-1:0]  rdata_o,
    output logic          empty_o,
    output logic          full_o,
    output logic [CW-1:0] count_o
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign empty_o = (count_o == '0);
    assign full_o  = single_i ? !empty_o : (count_o == CW'(DEPTH));
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign rdata_o = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_o <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count_o <= count_o + 1'b1;
            else if (do_pop && !do_push) count_o <= count_o - 1'b1;
        end
    end

    // R7
    push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !full_o) |=> (count_o == $past(count_o) + CW'(1)));

    // R8
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
endmodule

// File: rtl/sp_tx.sv
module sp_tx
    import sp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              en_i,
    input  line_cfg_t         cfg_i,
    input  logic              empty_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              pop_o,
    output logic              line_o,
    output logic              active_o
);
    tx_state_t         state, state_nx;
    logic [3:0]        cnt;
    logic [2:0]        bit_idx;
    logic              stop_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_r;
    logic              bit_end;
    logic [3:0]        wl;
    logic              bit_line;

    assign bit_end = tick_i && (cnt == 4'd15);
    assign wl      = wl_bits(cfg_i.wl_code);

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE:   if (tick_i && en_i && !empty_i) state_nx = TX_START;
            TX_START:  if (bit_end) state_nx = TX_DATA;
            TX_DATA:   if (bit_end && ({1'b0, bit_idx} == wl - 4'd1))
                           state_nx = cfg_i.par_en ? TX_PARITY : TX_STOP;
            TX_PARITY: if (bit_end) state_nx = TX_STOP;
            TX_STOP:   if (bit_end && (stop_idx == cfg_i.stop2))
                           state_nx = empty_i ? TX_IDLE : TX_START;
            default:   state_nx = TX_IDLE;
        endcase
    end

    assign pop_o = (state_nx == TX_START) && (state != TX_START);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            bit_idx  <= '0;
            stop_idx <= 1'b0;
            shreg    <= '0;
            par_r    <= 1'b0;
        end else begin
            if (tick_i && state != TX_IDLE) cnt <= cnt + 1'b1;
            if (pop_o) begin
                shreg   <= wl_mask(data_i, cfg_i.wl_code);
                par_r   <= par_bit(wl_mask(data_i, cfg_i.wl_code), cfg_i.par_even);
                bit_idx <= '0;
            end else if (state == TX_DATA && bit_end) begin
                shreg   <= shreg >> 1;
                bit_idx <= bit_idx + 1'b1;
            end
            if (state != TX_STOP)  stop_idx <= 1'b0;
            else if (bit_end)      stop_idx <= ~stop_idx;
        end
    end

    always_comb begin
        unique case (state)
            TX_START:  bit_line = 1'b0;
            TX_DATA:   bit_line = shreg[0];
            TX_PARITY: bit_line = par_r;
            default:   bit_line = 1'b1;
        endcase
        line_o   = cfg_i.brk ? 1'b0 : bit_line;
        active_o = (state != TX_IDLE);
    end

    // R3
    word_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_DATA) |-> ({1'b0, bit_idx} < wl));

    // R4
    two_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_STOP && bit_end && !stop_idx && cfg_i.stop2) |=> (state == TX_STOP));
endmodule

// File: rtl/sp_rx.sv
module sp_rx
    import sp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rx_i,
    input  line_cfg_t         cfg_i,
    output logic              push_o,
    output logic              ferr_o,
    output logic              perr_o,
    output logic [DATA_W-1:0] data_o
);
    rx_state_t         state, state_nx;
    logic [3:0]        cnt;
    logic [2:0]        bit_idx;
    logic [DATA_W-1:0] dreg;
    logic              perr_r;
    logic              mid_start, bit_end;
    logic [3:0]        wl;

    assign mid_start = tick_i && (cnt == 4'd7);
    assign bit_end   = tick_i && (cnt == 4'd15);
    assign wl        = wl_bits(cfg_i.wl_code);

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:      if (tick_i && !rx_i) state_nx = RX_START;
            RX_START:     if (mid_start) state_nx = rx_i ? RX_IDLE : RX_DATA;
            RX_DATA:      if (bit_end && ({1'b0, bit_idx} == wl - 4'd1))
                              state_nx = cfg_i.par_en ? RX_PARITY : RX_STOP;
            RX_PARITY:    if (bit_end) state_nx = RX_STOP;
            RX_STOP:      if (bit_end) state_nx = rx_i ? RX_IDLE : RX_WAIT_HIGH;
            RX_WAIT_HIGH: if (rx_i) state_nx = RX_IDLE;
            default:      state_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            dreg    <= '0;
            perr_r  <= 1'b0;
        end else begin
            unique case (state)
                RX_IDLE: begin
                    cnt     <= '0;
                    bit_idx <= '0;
                    if (state_nx == RX_START) begin
                        dreg   <= '0;
                        perr_r <= 1'b0;
                    end
                end
                RX_START: if (tick_i) cnt <= mid_start ? 4'd0 : cnt + 1'b1;
                RX_DATA: begin
                    if (tick_i) cnt <= cnt + 1'b1;
                    if (bit_end) begin
                        dreg[bit_idx] <= rx_i;
                        bit_idx       <= bit_idx + 1'b1;
                    end
                end
                RX_PARITY: begin
                    if (tick_i) cnt <= cnt + 1'b1;
                    if (bit_end) perr_r <= (rx_i != par_bit(dreg, cfg_i.par_even));
                end
                RX_STOP: if (tick_i) cnt <= cnt + 1'b1;
                default: cnt <= '0;
            endcase
        end
    end

    always_comb begin
        push_o = (state == RX_STOP) && bit_end;
        ferr_o = !rx_i;
        perr_o = perr_r;
        data_o = dreg;
    end

    // R8
    ferr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_WAIT_HIGH && !rx_i) |=> (state == RX_WAIT_HIGH));
endmodule

// File: rtl/serial_port_ctrl.sv
module serial_port_ctrl
    import sp_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        tx_line,
    input  logic        rx_line,
    output logic        tx_irq,
    output logic        rx_irq
);
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int HALF = DEPTH / 2;

    logic              port_en;
    line_cfg_t         cfg;
    logic              rx_meta, rx_sync;
    logic              tick16;
    logic              tx_push, tx_pop, tx_empty, tx_full, tx_active;
    logic [DATA_W-1:0] tx_head;
    logic [CW-1:0]     tx_count;
    logic              rx_push, rx_ferr, rx_perr, rx_pop, rx_empty, rx_full;
    logic [DATA_W-1:0] rx_data;
    logic [CW-1:0]     rx_count;
    logic [RXW_W-1:0]  rx_head_bits;
    rx_word_t          rx_in, rx_head;
    logic              ovr_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_en <= 1'b0;
            cfg     <= '0;
        end else if (bus_sel && bus_wr) begin
            if (bus_addr == A_CTRL) port_en <= bus_wdata[0];
            if (bus_addr == A_LINE) cfg     <= line_cfg_t'(bus_wdata[CFG_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_meta <= 1'b1;
            rx_sync <= 1'b1;
        end else begin
            rx_meta <= rx_line;
            rx_sync <= rx_meta;
        end
    end

    sp_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .en_i(port_en), .div_i(cfg.div), .tick_o(tick16)
    );

    assign tx_push = bus_sel && bus_wr && (bus_addr == A_DATA);

    sp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .single_i(!cfg.fifo_en),
        .push_i(tx_push), .wdata_i(bus_wdata[DATA_W-1:0]), .pop_i(tx_pop),
        .rdata_o(tx_head), .empty_o(tx_empty), .full_o(tx_full), .count_o(tx_count)
    );

    sp_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick_i(tick16), .en_i(port_en), .cfg_i(cfg),
        .empty_i(tx_empty), .data_i(tx_head), .pop_o(tx_pop),
        .line_o(tx_line), .active_o(tx_active)
    );

    sp_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick_i(tick16), .rx_i(rx_sync), .cfg_i(cfg),
        .push_o(rx_push), .ferr_o(rx_ferr), .perr_o(rx_perr), .data_o(rx_data)
    );

    always_comb begin
        rx_in.ovr  = ovr_pend;
        rx_in.perr = rx_perr;
        rx_in.ferr = rx_ferr;
        rx_in.data = rx_data;
    end

    assign rx_pop = bus_sel && !bus_wr && (bus_addr == A_DATA) && !rx_empty;

    sp_fifo #(.W(RXW_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .single_i(!cfg.fifo_en),
        .push_i(rx_push && !rx_full), .wdata_i(rx_in), .pop_i(rx_pop),
        .rdata_o(rx_head_bits), .empty_o(rx_empty), .full_o(rx_full), .count_o(rx_count)
    );

    assign rx_head = rx_word_t'(rx_head_bits);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovr_pend <= 1'b0;
        else if (rx_push) ovr_pend <= rx_full;
    end

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = {31'b0, port_en};
            A_LINE:  bus_rdata = 32'(cfg);
            A_DATA:  bus_rdata = 32'(rx_head);
            default: bus_rdata = {29'b0, (tx_active || !tx_empty), tx_full, rx_empty};
        endcase
        tx_irq = port_en && (cfg.fifo_en ? (tx_count <= CW'(HALF)) : tx_empty);
        rx_irq = port_en && !rx_empty;
    end

    // R11
    gated_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |-> !tick16);

    // R9
    drop_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !rx_pop) |=> (rx_count == $past(rx_count)));
endmodule

// File: tb/serial_port_ctrl_tb.sv
module serial_port_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        tx_line, tx_irq, rx_irq;
    logic        loop_mode = 1'b0, drv_line = 1'b1;
    logic        rx_w;

    always #10 clk = ~clk;
    assign rx_w = loop_mode ? tx_line : drv_line;

    serial_port_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_line(tx_line), .rx_line(rx_w), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    int checks = 0, fails = 0, cyc = 0;
    int cfg_div = 1, cfg_wl = 8;
    bit cfg_pen = 0, cfg_even = 0, cfg_s2 = 0, cfg_fifo = 1;
    int mon_data [128];
    int mon_t    [128];
    bit mon_pok  [128];
    bit mon_sok  [128];
    int mon_n = 0;
    bit mon_on = 1;
    int m_t0, m_d;
    bit m_pb, m_sok;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int bitc();  return 16 * (cfg_div + 1); endfunction
    function automatic int flen();  return 2 + cfg_wl + int'(cfg_pen) + int'(cfg_s2); endfunction
    function automatic int mask(input int d); return d & ((1 << cfg_wl) - 1); endfunction
    function automatic bit epar(input int d);
        return cfg_even ? ^mask(d) : ~(^mask(d));
    endfunction

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a[1:0]; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a[1:0];
        #1 d = int'(bus_rdata);
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic set_line(input bit brk);
        int v;
        v = ((cfg_wl - 5) << 17) | (int'(cfg_fifo) << 16) | (int'(cfg_s2) << 15) |
            (int'(cfg_even) << 14) | (int'(cfg_pen) << 13) | (int'(brk) << 12) | cfg_div;
        wr(1, v);
    endtask

    task automatic drive_bit(input bit b);
        drv_line = b;
        repeat (bitc()) @(negedge clk);
    endtask

    task automatic send_frame(input int d, input bit bad_par, input bit bad_stop);
        @(negedge clk);
        drive_bit(1'b0);
        for (int i = 0; i < cfg_wl; i++) drive_bit(d[i]);
        if (cfg_pen) drive_bit(epar(d) ^ bad_par);
        drive_bit(!bad_stop);
        if (cfg_s2) drive_bit(1'b1);
        drive_bit(1'b1);
    endtask

    task automatic wait_idle();
        int s;
        do rd(3, s); while (s[2]);
    endtask

    // serial monitor on tx_line
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on && tx_line == 1'b0) begin
                m_t0 = cyc; m_d = 0; m_pb = 1; m_sok = 1;
                repeat (bitc() / 2) @(negedge clk);
                for (int i = 0; i < cfg_wl; i++) begin
                    repeat (bitc()) @(negedge clk);
                    m_d[i] = tx_line;
                end
                if (cfg_pen) begin
                    repeat (bitc()) @(negedge clk);
                    m_pb = (tx_line == epar(m_d));
                end
                for (int i = 0; i < 1 + int'(cfg_s2); i++) begin
                    repeat (bitc()) @(negedge clk);
                    if (!tx_line) m_sok = 0;
                end
                if (mon_n < 128) begin
                    mon_data[mon_n] = m_d; mon_t[mon_n] = m_t0;
                    mon_pok[mon_n] = m_pb; mon_sok[mon_n] = m_sok;
                    mon_n++;
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        report();
    end

    initial begin
        int s, d, n, base, seedv;
        int vals [8];
        seedv = $urandom(32'h51A7);
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R1 reset state
        check(tx_line == 1'b1, "R1 tx_line", tx_line, 1);
        check(tx_irq == 0 && rx_irq == 0, "R1 irqs", {tx_irq, rx_irq}, 0);
        rd(3, s); check(s == 1, "R1 status", s, 1);
        rd(0, s); check(s == 0, "R1 control", s, 0);
        rd(1, s); check(s == 0, "R1 line", s, 0);

        wr(0, 1);
        // random configurations, loopback
        loop_mode = 1;
        for (int it = 0; it < 8; it++) begin
            cfg_div = $urandom_range(0, 2); cfg_wl = $urandom_range(5, 8);
            cfg_pen = 1'($urandom_range(0, 1)); cfg_even = 1'($urandom_range(0, 1));
            cfg_s2 = 1'($urandom_range(0, 1)); cfg_fifo = 1;
            set_line(0);
            n = $urandom_range(2, 6);
            base = mon_n;
            for (int k = 0; k < n; k++) begin
                vals[k] = $urandom_range(0, 255);
                wr(2, vals[k]);
            end
            wait_idle();
            check(mon_n - base == n, "R7 frame count", mon_n - base, n);
            for (int k = 0; k < n; k++) begin
                check(mon_data[base+k] == mask(vals[k]), "R3 tx data", mon_data[base+k], mask(vals[k]));
                check(mon_pok[base+k], "R5 parity bit", 0, 1);
                check(mon_sok[base+k], "R4 stop bits high", 0, 1);
                if (k > 0)
                    check(mon_t[base+k] - mon_t[base+k-1] == flen() * bitc(), "R2 frame spacing",
                          mon_t[base+k] - mon_t[base+k-1], flen() * bitc());
            end
            check(rx_irq == 1, "R12 rx_irq set", rx_irq, 1);
            for (int k = 0; k < n; k++) begin
                rd(2, d);
                check(d == mask(vals[k]), "R8 rx data", d, mask(vals[k]));
            end
            check(rx_irq == 0, "R12 rx_irq clear", rx_irq, 0);
        end

        // R6 break
        loop_mode = 0;
        cfg_div = 1; cfg_wl = 8; cfg_pen = 0; cfg_s2 = 0; cfg_fifo = 1;
        mon_on = 0;
        set_line(1);
        repeat (3) @(negedge clk);
        check(tx_line == 0, "R6 break low", tx_line, 0);
        repeat (200) @(negedge clk);
        check(tx_line == 0, "R6 break held", tx_line, 0);
        set_line(0);
        repeat (3) @(negedge clk);
        check(tx_line == 1, "R6 break release", tx_line, 1);
        mon_on = 1;

        // R8 error flags via driven frames
        cfg_pen = 1; cfg_even = 1;
        set_line(0);
        send_frame(8'h3C, 1, 0); rd(2, d); check(d == 32'h23C, "R8 parity error flag", d, 32'h23C);
        send_frame(8'h81, 0, 1); rd(2, d); check(d == 32'h181, "R8 framing error flag", d, 32'h181);
        send_frame(8'h55, 0, 0); rd(2, d); check(d == 32'h055, "R8 recovery after framing error", d, 32'h055);

        // R9 overrun with 16-entry queue
        cfg_pen = 0;
        set_line(0);
        for (int k = 0; k < 17; k++) send_frame(k + 1, 0, 0);
        check(rx_irq == 1, "R12 rx_irq with data", rx_irq, 1);
        for (int k = 0; k < 16; k++) begin
            rd(2, d);
            check(d == k + 1, "R7 rx order", d, k + 1);
        end
        rd(3, s); check(s[0] == 1, "R8 rx empty flag", s, 1);
        check(rx_irq == 0, "R12 rx_irq drained", rx_irq, 0);
        send_frame(8'h77, 0, 0); rd(2, d); check(d == 32'h477, "R9 overrun flag", d, 32'h477);
        send_frame(8'h78, 0, 0); rd(2, d); check(d == 32'h078, "R9 overrun cleared", d, 32'h078);

        // R7 single-slot receive
        cfg_fifo = 0;
        set_line(0);
        send_frame(8'h11, 0, 0); send_frame(8'h22, 0, 0);
        rd(2, d); check(d == 32'h011, "R7 single slot keeps first", d, 32'h011);
        rd(3, s); check(s[0] == 1, "R7 single slot empty", s, 1);
        send_frame(8'h33, 0, 0);
        rd(2, d); check(d == 32'h433, "R9 overrun single slot", d, 32'h433);

        // R11 disabled port, R7 tx full, R12 tx_irq
        wr(0, 0);
        cfg_fifo = 1;
        set_line(0);
        for (int k = 0; k < 16; k++) wr(2, (k * 7 + 3) & 255);
        rd(3, s); check(s[1] == 1, "R7 tx full", s, 2);
        wr(2, 8'hEE);
        base = mon_n;
        send_frame(8'h5A, 0, 0);
        rd(3, s); check(s[0] == 1, "R11 no receive when disabled", s, 1);
        check(tx_line == 1 && mon_n == base, "R11 no transmit when disabled", mon_n - base, 0);
        wr(0, 1);
        repeat (3) @(negedge clk);
        check(tx_irq == 0, "R12 tx_irq above half", tx_irq, 0);
        wait_idle();
        check(tx_irq == 1, "R12 tx_irq empty", tx_irq, 1);
        check(mon_n - base == 16, "R7 full queue drained, extra dropped", mon_n - base, 16);
        for (int k = 0; k < 16; k++)
            check(mon_data[base+k] == ((k * 7 + 3) & 255), "R7 tx order", mon_data[base+k], (k * 7 + 3) & 255);

        // R7 single-slot transmit
        wr(0, 0);
        cfg_fifo = 0;
        set_line(0);
        wr(2, 8'h3C);
        rd(3, s); check(s[1] == 1, "R7 single slot tx full", s, 2);
        wr(2, 8'h99);
        base = mon_n;
        wr(0, 1);
        wait_idle();
        check(mon_n - base == 1 && mon_data[base] == 8'h3C, "R7 single slot tx", mon_data[base], 8'h3C);

        // R10 busy window
        cfg_div = 2; cfg_fifo = 1;
        set_line(0);
        wr(2, 8'hC3);
        do @(negedge clk); while (tx_line);
        repeat (flen() * bitc() - bitc() / 2) @(negedge clk);
        rd(3, s); check(s[2] == 1, "R10 busy during stop", s, 4);
        repeat (bitc() / 2) @(negedge clk);
        rd(3, s); check(s[2] == 0, "R10 busy clear after stop", s, 0);

        report();
    end
endmodule